// File: doc/BRIEF.md
# Serial audio transmit controller

This block feeds a codec's serial data line from samples that a host writes into an eight-word transmit queue. The queue is treated as two halves of four words. A single holding word stands between the queue and a parallel-to-serial shift register. The holding word refills itself from the queue as soon as it is empty. The shift register takes the holding word only when the external frame-start strobe fires. After that it sends one bit per serial-clock tick, most significant bit first.

The block has three sticky condition flags: half drained, underrun and overrun. The host reads them on a status port and clears them by writing ones. In programmed-I/O mode, the enabled flags drive an interrupt. In DMA mode, an active-low request line with hysteresis keeps the queue topped up. Frame timing comes entirely from the strobe inputs.

Top module: `audio_tx_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first stimulus, the outputs are `sdo_o`=0, `status_o`=0, `irq_o`=0 and `dma_req_no`=1.
- R2: The queue holds up to 8 words. Words leave the block in the order they were accepted.
- R3: When the holding word is empty and the queue is not, the oldest queue word moves into the holding word on the next edge. `frame_start_i` copies the holding word into the shift register and empties the holding word. `sdo_o` is bit 31 of the shift register. Each `bit_tick_i` without `frame_start_i` shifts the register left by one and fills with 0. `frame_start_i` wins over `bit_tick_i` in the same cycle.
- R4: A `frame_start_i` that finds the holding word empty loads all zeros into the shift register and sets `status_o[1]` (underrun).
- R5: `status_o[0]` (half drained) is set when a move out of the queue takes the last word of a half, that is, the 4th, 8th, 12th and so on word moved out since reset.
- R6: A write while the queue holds 8 words is dropped and sets `status_o[2]` (overrun). The holding word does not count towards the 8.
- R7: Flags are sticky. A 1 in `status_clr_i` clears the matching flag on the next edge. A flag set in the same cycle as its clear stays set.
- R8: `irq_o` is the OR of `status_o & irq_en_i` when `dma_mode_i`=0, and is 0 when `dma_mode_i`=1.
- R9: When `dma_mode_i`=1, the request becomes active (`dma_req_no`=0) one edge after the queue holds 2 or fewer words. It becomes inactive one edge after the queue holds 7 or more words. Between those levels it holds its value. When `dma_mode_i`=0, it goes inactive one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_mode_i | input | 1 | 1 selects DMA mode, 0 selects programmed-I/O |
| irq_en_i | input | 3 | Per-flag interrupt enables |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 32 | Host write word |
| frame_start_i | input | 1 | Frame-start strobe, loads the shift register |
| bit_tick_i | input | 1 | Serial clock tick, shifts one bit |
| status_clr_i | input | 3 | Write-one-to-clear for the flags |
| sdo_o | output | 1 | Serial data out |
| status_o | output | 3 | Flags: [0] half drained, [1] underrun, [2] overrun |
| irq_o | output | 1 | Interrupt request |
| dma_req_no | output | 1 | DMA request, active low |

## Verification
A wrong queue count or a wrong pointer has two visible effects. The serial stream shows a repeated, lost or reordered word at the next frame strobe. The overrun flag or the DMA request also changes one edge early or late. A stale holding-word valid bit shows at the very next frame strobe, as a spurious or missing underrun flag together with a wrong first serial bit. The reference model is compared on every cycle, so each of these faults is reported in the cycle where the port first differs.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  localparam int unsigned FLAG_W   = 3;
  localparam int unsigned FLG_HALF = 0;
  localparam int unsigned FLG_UNDR = 1;
  localparam int unsigned FLG_OVRN = 2;
  typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned FW   = $clog2(DEPTH + 1),
  localparam int unsigned HALF = DEPTH / 2,
  localparam int unsigned HW   = $clog2(HALF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [FW-1:0] fill_o,
  output logic          drop_o,
  output logic          half_drained_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [FW-1:0] count;
  logic          accept, do_pop;

  assign accept = push_i && (count != FW'(DEPTH));
  assign drop_o = push_i && !accept;
  assign do_pop = pop_i && (count != '0);
  // a pop of the last slot of either half drains that half
  assign half_drained_o = do_pop && (rd_ptr[HW-1:0] == HW'(HALF - 1));
  assign data_o = mem[rd_ptr];
  assign fill_o = count;

  always_ff @(posedge clk_i) begin
    if (accept) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop) rd_ptr <= rd_ptr + AW'(1);
      unique case ({accept, do_pop})
        2'b10:   count <= count + FW'(1);
        2'b01:   count <= count - FW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/audio_tx_serializer.sv
module audio_tx_serializer #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fifo_avail_i,
  input  logic [W-1:0] fifo_data_i,
  input  logic         frame_start_i,
  input  logic         bit_tick_i,
  output logic         pop_o,
  output logic         buf_valid_o,
  output logic         underrun_o,
  output logic         sdo_o
);
  logic [W-1:0] hold_q, shift_q;
  logic         hold_vld;

  assign pop_o       = !hold_vld && fifo_avail_i;
  assign underrun_o  = frame_start_i && !hold_vld;
  assign buf_valid_o = hold_vld;
  assign sdo_o       = shift_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      hold_vld <= 1'b0;
      shift_q  <= '0;
    end else begin
      if (frame_start_i) begin
        shift_q  <= hold_vld ? hold_q : '0;
        hold_vld <= 1'b0;
      end else if (bit_tick_i) begin
        shift_q  <= {shift_q[W-2:0], 1'b0};
      end
      if (pop_o) begin
        hold_q   <= fifo_data_i;
        hold_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_tx_flags.sv
module audio_tx_flags
  import audio_tx_pkg::*;
#(
  parameter int unsigned FW      = 4,
  parameter int unsigned LO_MARK = 2,
  parameter int unsigned HI_MARK = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  flags_t        set_i,
  input  flags_t        clr_i,
  input  flags_t        irq_en_i,
  input  logic          dma_mode_i,
  input  logic [FW-1:0] fill_i,
  output flags_t        status_o,
  output logic          irq_o,
  output logic          dma_req_no
);
  flags_t flags_q;
  logic   req_q;

  assign status_o   = flags_q;
  assign irq_o      = !dma_mode_i && |(flags_q & irq_en_i);
  assign dma_req_no = !req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      req_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_i) | set_i;  // set wins over clear
      if (!dma_mode_i)                   req_q <= 1'b0;
      else if (fill_i <= FW'(LO_MARK))   req_q <= 1'b1;
      else if (fill_i >= FW'(HI_MARK))   req_q <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl
  import audio_tx_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned LO_MARK = 2,
  parameter int unsigned HI_MARK = 7,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_mode_i,
  input  logic [FLAG_W-1:0] irq_en_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              frame_start_i,
  input  logic              bit_tick_i,
  input  logic [FLAG_W-1:0] status_clr_i,
  output logic              sdo_o,
  output logic [FLAG_W-1:0] status_o,
  output logic              irq_o,
  output logic              dma_req_no
);
  logic [W-1:0]      fifo_data;
  logic [FILL_W-1:0] fill;
  logic              pop, drop, half_drained, underrun, buf_valid;
  flags_t            set_vec;

  audio_tx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i        (wr_en_i),
    .data_i        (wr_data_i),
    .pop_i         (pop),
    .data_o        (fifo_data),
    .fill_o        (fill),
    .drop_o        (drop),
    .half_drained_o(half_drained)
  );

  audio_tx_serializer #(.W(W)) u_ser (
    .clk_i, .rst_ni,
    .fifo_avail_i (fill != '0),
    .fifo_data_i  (fifo_data),
    .frame_start_i,
    .bit_tick_i,
    .pop_o        (pop),
    .buf_valid_o  (buf_valid),
    .underrun_o   (underrun),
    .sdo_o
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_HALF] = half_drained;
    set_vec[FLG_UNDR] = underrun;
    set_vec[FLG_OVRN] = drop;
  end

  audio_tx_flags #(.FW(FILL_W), .LO_MARK(LO_MARK), .HI_MARK(HI_MARK)) u_flags (
    .clk_i, .rst_ni,
    .set_i     (set_vec),
    .clr_i     (status_clr_i),
    .irq_en_i,
    .dma_mode_i,
    .fill_i    (fill),
    .status_o,
    .irq_o,
    .dma_req_no
  );
endmodule

// File: rtl/audio_tx_ctrl_chk.sv
module audio_tx_ctrl_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned FW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dma_mode_i,
  input logic          wr_en_i,
  input logic          frame_start_i,
  input logic [2:0]    status_clr_i,
  input logic [2:0]    status_o,
  input logic          irq_o,
  input logic          dma_req_no,
  input logic [FW-1:0] fill_i,
  input logic          buf_valid_i
);
  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= FW'(DEPTH)); // R2
  AST_UNDERRUN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !buf_valid_i |=> status_o[1]); // R4
  AST_OVERRUN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && fill_i == FW'(DEPTH) |=> status_o[2] && fill_i != '0); // R6
  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & $past(status_o & ~status_clr_i)) == $past(status_o & ~status_clr_i))); // R7
  AST_IRQ_QUIET_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_mode_i |-> !irq_o); // R8
  AST_REQ_IDLE_PIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_mode_i |=> dma_req_no); // R9
  AST_REQ_LOW_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_mode_i && fill_i <= FW'(2) |=> !dma_req_no); // R9
endmodule

bind audio_tx_ctrl audio_tx_ctrl_chk #(.DEPTH(DEPTH), .FW(FILL_W)) u_chk (
  .clk_i, .rst_ni, .dma_mode_i, .wr_en_i, .frame_start_i, .status_clr_i,
  .status_o, .irq_o, .dma_req_no,
  .fill_i      (fill),
  .buf_valid_i (buf_valid)
);

// File: tb/audio_tx_ctrl_bench.sv
`timescale 1ns/1ps
module audio_tx_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_mode = 1'b0;
  logic [2:0]  irq_en = 3'b111;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        fs = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  clr = '0;
  logic        sdo, irq, dreq_n;
  logic [2:0]  status;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  audio_tx_ctrl u_audio_tx_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .dma_mode_i(dma_mode), .irq_en_i(irq_en),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .frame_start_i(fs), .bit_tick_i(tick),
    .status_clr_i(clr), .sdo_o(sdo), .status_o(status), .irq_o(irq),
    .dma_req_no(dreq_n)
  );

  // behavioural reference model
  logic [31:0] q[$];
  logic [31:0] m_buf, m_sh;
  bit          m_bv, m_req;
  logic [2:0]  m_st;
  int          m_pops;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_buf = '0; m_sh = '0; m_bv = 0; m_req = 0; m_st = '0; m_pops = 0;
    end else begin
      int cnt;
      bit pop;
      logic [2:0] setv;
      cnt  = q.size();
      pop  = !m_bv && cnt > 0;
      setv = '0;
      if (fs) begin
        if (m_bv) begin m_sh = m_buf; m_bv = 0; end
        else begin m_sh = '0; setv[1] = 1'b1; end
      end else if (tick) m_sh = {m_sh[30:0], 1'b0};
      if (pop) begin
        m_buf = q.pop_front(); m_bv = 1;
        if (m_pops % 4 == 3) setv[0] = 1'b1;
        m_pops++;
      end
      if (wr_en) begin
        if (cnt < 8) q.push_back(wr_data); else setv[2] = 1'b1;
      end
      if (!dma_mode) m_req = 0;
      else if (cnt <= 2) m_req = 1;
      else if (cnt >= 7) m_req = 0;
      m_st = (m_st & ~clr) | setv;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 R3 sdo", {31'd0, sdo}, {31'd0, m_sh[31]});
      check("R4 R5 R6 R7 status", {29'd0, status}, {29'd0, m_st});
      check("R8 irq", {31'd0, irq}, {31'd0, !dma_mode && |(m_st & irq_en)});
      check("R9 dma_req_no", {31'd0, dreq_n}, {31'd0, !m_req});
    end
  end

  task automatic step(bit w, logic [31:0] d, bit f, bit t, logic [2:0] c);
    @(posedge clk); #1;
    wr_en = w; wr_data = d; fs = f; tick = t; clr = c;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, '0);
  endtask
  task automatic sample();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sdo in reset", {31'd0, sdo}, 32'd0);
    check("R1 status in reset", {29'd0, status}, 32'd0);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    check("R1 dma_req_no in reset", {31'd0, dreq_n}, 32'd1);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(2); sample();
    check("R1 status after release", {29'd0, status}, 32'd0);

    // R2 R3: two words, frame load and serial shifting
    step(1, 32'hC3A5_0F01, 0, 0, '0);
    step(1, 32'h8000_0001, 0, 0, '0);
    idle(3);
    step(0, '0, 1, 0, '0); idle(1); sample();
    check("R3 first bit of first word", {31'd0, sdo}, 32'd1);
    for (int i = 0; i < 31; i++) step(0, '0, 0, 1, '0);
    step(0, '0, 1, 1, '0);             // frame wins over tick
    for (int i = 0; i < 5; i++) step(0, '0, 0, 1, '0);
    idle(2);
    // R4: underrun with empty holding word
    step(0, '0, 1, 0, '0); idle(1); sample();
    check("R4 underrun flag", {31'd0, status[1]}, 32'd1);
    check("R4 zeros sent", {31'd0, sdo}, 32'd0);
    check("R8 irq from underrun", {31'd0, irq}, 32'd1);
    // R7 clear
    step(0, '0, 0, 0, 3'b111); idle(1); sample();
    check("R7 cleared", {29'd0, status}, 32'd0);

    // R6 overrun: 12 back-to-back writes
    for (int i = 0; i < 12; i++) step(1, 32'h5A00_0000 + i, 0, 0, '0);
    idle(2); sample();
    check("R6 overrun flag", {31'd0, status[2]}, 32'd1);
    // R5 drain nine words
    for (int k = 0; k < 9; k++) begin
      step(0, '0, 1, 0, '0);
      for (int i = 0; i < 4; i++) step(0, '0, 0, 1, '0);
      idle(2);
    end
    sample();
    check("R5 half drained flag", {31'd0, status[0]}, 32'd1);
    step(0, '0, 0, 0, 3'b111); idle(1);
    // R7 set wins over clear
    step(0, '0, 1, 0, 3'b010); idle(1); sample();
    check("R7 set beats clear", {31'd0, status[1]}, 32'd1);

    // R8 enable masking
    irq_en = 3'b001; idle(1); sample();
    check("R8 masked irq", {31'd0, irq}, 32'd0);
    irq_en = 3'b010; idle(1); sample();
    check("R8 enabled irq", {31'd0, irq}, 32'd1);

    // R9 DMA hysteresis
    dma_mode = 1'b1; idle(2); sample();
    check("R8 irq quiet in DMA", {31'd0, irq}, 32'd0);
    check("R9 request on empty", {31'd0, dreq_n}, 32'd0);
    for (int i = 0; i < 9; i++) step(1, 32'h1234_0000 + i, 0, 0, '0);
    idle(2); sample();
    check("R9 release when full", {31'd0, dreq_n}, 32'd1);
    for (int k = 0; k < 3; k++) begin step(0, '0, 1, 0, '0); idle(3); end
    sample();
    check("R9 hysteresis holds at 5", {31'd0, dreq_n}, 32'd1);
    for (int k = 0; k < 3; k++) begin step(0, '0, 1, 0, '0); idle(3); end
    sample();
    check("R9 request at 2", {31'd0, dreq_n}, 32'd0);
    dma_mode = 1'b0; idle(2); sample();
    check("R9 idle out of DMA", {31'd0, dreq_n}, 32'd1);
    idle(4);
    finish_run();
  end
endmodule